// File: doc/BRIEF.md
# Valley-Synchronized Switching Cycle Timer

This block sequences the gate pulse of a boost power stage that runs in critical or discontinuous conduction. It takes a digitized valley comparator output and an on-time in clock cycles. It also takes a dead time in clock cycles, which the control loop derives from its error level. From these it decides when the switch turns on. A turn-on is always placed on a detected valley edge when one is available. The dead time, a two-tier period clamp and a long restart watchdog govern which valley is used, or whether the gate is forced high without one.

The off time begins at gate turn-off. Valley edges inside a blanking window are discarded. The first valid valley marks the end of demagnetization, and the dead time is counted from that point. A later valley starts the next pulse once the dead time has passed. If no valid valley arrives during a whole watchdog interval, the block raises a one-cycle request for a pin short-to-ground test. It then either restarts switching or, if a short is reported, stops in a halted state. A low enable acts as a fault input: it clears all timing and holds the gate low.

All times are parameters in clock cycles. The defaults assume a 50 MHz clock: 600 ns blanking, 220 ns turn-on delay, 32 µs and 36 µs period clamps, and a 200 µs watchdog.

Top module: `valley_cycle_timer`

## Requirements
- R1: While rst_n is low, gate, gnd_check_req and halted are all low; after release the block starts an off time with off-cycle 0 and switching-period count 0.
- R2: With tdead_cyc = 0, the first valid valley edge (a rising edge of zcd) in the off time starts a turn-on.
- R3: A zcd rising edge seen at off-cycle n, where off-cycle 0 is the first cycle the gate is low, is discarded when n < BLANK_CYC. It does not count as a valley and does not count as having seen one.
- R4: With a nonzero dead time, let the first valid valley be at off-cycle f. A later valley at off-cycle v starts a turn-on only if v - f >= tdead_cyc.
- R5: A valid valley at a switching-period count of at least SOFT_PERIOD starts a turn-on whatever the dead time. The period count is 0 in the first gate-high cycle.
- R6: If a valid valley has been seen in the current off time and the period count reaches HARD_PERIOD, a turn-on starts without waiting for a further valley.
- R7: If no valid valley occurs in the off time, gnd_check_req is high for exactly one cycle, at off-cycle WDOG_CYC. If gnd_short is low in that cycle, a turn-on starts. gnd_check_req never rises in any other case.
- R8: If gnd_short is high while gnd_check_req is high, halted goes high on the next cycle. It stays high with the gate low until enable goes low.
- R9: Every turn-on decision is followed by exactly DELAY_CYC low cycles before the gate rises. So a decision at off-cycle n gives an off time of n + 1 + DELAY_CYC cycles.
- R10: The gate stays high for exactly ton_cyc cycles, or for one cycle when ton_cyc is 0.
- R11: enable low forces gate and gnd_check_req low in the same cycle, clears halted and all counters, and releasing enable restarts exactly as after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low is a fault that stops switching |
| zcd | input | 1 | Valley comparator output; a rising edge is a valley event |
| ton_cyc | input | TW | On time in clock cycles |
| tdead_cyc | input | TW | Dead time in clock cycles, counted from the first valley |
| gnd_short | input | 1 | Result of the short-to-ground test, read while gnd_check_req is high |
| gate | output | 1 | Switch gate drive |
| gnd_check_req | output | 1 | One-cycle request for the short-to-ground test |
| halted | output | 1 | Switching stopped after a reported short |

## Verification
The bench measures each off time to the exact cycle and targets the boundaries. These are a valley exactly at the end of blanking, a valley exactly one dead time after the first, and a valley exactly at the soft period limit. A design off by one at any of these would turn on one valley early or late, and the off-time count would show it. A valley inside the blanking window, followed by silence, must still lead to the watchdog path. A design that counted that valley as seen would instead force a turn-on at the hard period limit. The halted state and the immediate gate cut on a fault are checked during a live pulse, where a registered fault path would leave the gate high for a stray cycle.

// File: rtl/valley_cycle_timer.sv
module valley_cycle_timer #(
  parameter int TW          = 16,
  parameter int BLANK_CYC   = 30,
  parameter int DELAY_CYC   = 11,
  parameter int SOFT_PERIOD = 1600,
  parameter int HARD_PERIOD = 1800,
  parameter int WDOG_CYC    = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          zcd,
  input  logic [TW-1:0] ton_cyc,
  input  logic [TW-1:0] tdead_cyc,
  input  logic          gnd_short,
  output logic          gate,
  output logic          gnd_check_req,
  output logic          halted
);

  localparam logic [TW-1:0] BLANK_W  = TW'(BLANK_CYC);
  localparam logic [TW-1:0] DLY_LAST = TW'(DELAY_CYC - 1);
  localparam logic [TW-1:0] SOFT_W   = TW'(SOFT_PERIOD);
  localparam logic [TW-1:0] HARD_W   = TW'(HARD_PERIOD);
  localparam logic [TW-1:0] WD_LAST  = TW'(WDOG_CYC - 1);
  localparam logic [TW-1:0] CNT_MAX  = '1;

  typedef enum logic [2:0] {S_OFF, S_DLY, S_ON, S_CHK, S_HALT} state_t;

  state_t        st;
  logic [TW-1:0] cnt, per, dcnt;
  logic          seen, zcd_q;
  logic          valley, dead_ok, fire, wd_hit, on_done;

  assign valley  = (st == S_OFF) && zcd && !zcd_q && (cnt >= BLANK_W);
  assign dead_ok = seen ? (dcnt >= tdead_cyc) : (tdead_cyc == '0);
  assign fire    = (valley && (dead_ok || per >= SOFT_W)) || (seen && per >= HARD_W);
  assign wd_hit  = !seen && !valley && (cnt == WD_LAST);
  assign on_done = (ton_cyc <= TW'(1)) || (cnt == ton_cyc - 1'b1);

  assign gate          = enable && (st == S_ON);
  assign gnd_check_req = enable && (st == S_CHK);
  assign halted        = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      st    <= S_OFF;
      cnt   <= '0;
      per   <= '0;
      dcnt  <= '0;
      seen  <= 1'b0;
      zcd_q <= rst_n ? zcd : 1'b0;
    end else begin
      zcd_q <= zcd;
      if (per < HARD_W) per <= per + 1'b1;
      case (st)
        S_OFF: begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (seen && dcnt != CNT_MAX) dcnt <= dcnt + 1'b1;
          if (valley && !seen) begin
            seen <= 1'b1;
            dcnt <= TW'(1);
          end
          if (fire) begin
            st   <= S_DLY;
            cnt  <= '0;
            seen <= 1'b0;
            dcnt <= '0;
          end else if (wd_hit) begin
            st  <= S_CHK;
            cnt <= '0;
          end
        end
        S_CHK: begin
          if (gnd_short) st <= S_HALT;
          else begin
            st  <= S_DLY;
            cnt <= '0;
          end
        end
        S_DLY: begin
          if (cnt == DLY_LAST) begin
            st  <= S_ON;
            cnt <= '0;
            per <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_ON: begin
          if (on_done) begin
            st  <= S_OFF;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_HALT: st <= S_HALT;
        default: st <= S_OFF;
      endcase
    end
  end

endmodule

module valley_cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic gnd_short,
  input logic gate,
  input logic gnd_check_req,
  input logic halted
);

  a_r8_halt_low: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !gate);

  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted && enable |=> halted);

  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    gnd_check_req |=> !gnd_check_req);

  a_r7_short_halts: assert property (@(posedge clk) disable iff (!rst_n)
    gnd_check_req && gnd_short |=> halted);

  a_r11_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !gate && !gnd_check_req);

  a_r9_low_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |=> !gate);

endmodule

bind valley_cycle_timer valley_cycle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .gnd_short(gnd_short),
  .gate(gate), .gnd_check_req(gnd_check_req), .halted(halted)
);

// File: tb/valley_cycle_timer_test.sv
`timescale 1ns/1ps
module valley_cycle_timer_test;

  localparam int TW = 12;
  localparam int NV = 11;
  // ton, dead, valley a, b, c, expected off cycles, expected requests
  localparam int VEC [NV][7] = '{
    '{10,   0,  8, -1, -1,  12, 0},
    '{12,   0,  2,  7, -1,  11, 0},
    '{20,  10,  5, 10, 16,  20, 0},
    '{20,  10,  5, 15, -1,  19, 0},
    '{20, 200,  6, 30, 45,  49, 0},
    '{20, 200,  6, 35, -1,  64, 0},
    '{ 5, 200,  6, 40, -1,  44, 0},
    '{ 1,   0,  4, -1, -1,   8, 0},
    '{ 0,   0, 10, -1, -1,  14, 0},
    '{10,   0, -1, -1, -1, 304, 1},
    '{10,   0,  3, -1, -1, 304, 1}
  };

  logic clk = 0, rst_n = 0, enable = 1, zcd = 0, gnd_short = 0;
  logic [TW-1:0] ton_cyc = '0, tdead_cyc = '0;
  logic gate, gnd_check_req, halted;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  valley_cycle_timer #(.TW(TW), .BLANK_CYC(4), .DELAY_CYC(3), .SOFT_PERIOD(60),
                       .HARD_PERIOD(80), .WDOG_CYC(300)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .zcd(zcd), .ton_cyc(ton_cyc),
    .tdead_cyc(tdead_cyc), .gnd_short(gnd_short), .gate(gate),
    .gnd_check_req(gnd_check_req), .halted(halted));

  function automatic string row_tag(int r);
    case (r)
      0: return "R2 critical mode valley";
      1: return "R3 blanked edge then valley";
      2: return "R4 dead time not yet served";
      3: return "R4 dead time boundary";
      4: return "R5 soft period valley";
      5: return "R6 hard period force";
      6: return "R5 soft period boundary";
      7: return "R3 blank window boundary";
      8: return "R10 zero on time";
      9: return "R7 watchdog restart";
      default: return "R3 R7 blanked edge only";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at the negedge of off-cycle 0; returns at the first low sample after the pulse.
  task automatic run(int ton, int dead, int a, int b, int c, int exp_off, int exp_req, string tag);
    int i = 0;
    int req = 0;
    int hi = 0;
    ton_cyc = TW'(ton);
    tdead_cyc = TW'(dead);
    while (gate == 1'b0 && i < 2000) begin
      zcd = (i == a || i == b || i == c);
      if (gnd_check_req) req++;
      @(negedge clk);
      i++;
    end
    zcd = 0;
    check(i == exp_off, {tag, " (R9 off time)"}, i, exp_off);
    check(req == exp_req, {tag, " (R7 check requests)"}, req, exp_req);
    while (gate == 1'b1 && hi < 2000) begin
      @(negedge clk);
      hi++;
    end
    check(hi == ((ton == 0) ? 1 : ton), {tag, " (R10 high time)"}, hi, (ton == 0) ? 1 : ton);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi_cnt;
    int req_cnt;
    int i;
    repeat (4) begin
      @(negedge clk);
      check(!gate && !gnd_check_req && !halted, "R1 reset outputs", {gate, gnd_check_req, halted}, 0);
    end
    rst_n = 1;
    run(10, 0, 5, -1, -1, 9, 0, "R1 R2 start after reset");

    for (int r = 0; r < NV; r++)
      run(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4], VEC[r][5], VEC[r][6], row_tag(r));

    gnd_short = 1;
    hi_cnt = 0;
    req_cnt = 0;
    for (int k = 0; k < 400; k++) begin
      if (gate) hi_cnt++;
      if (gnd_check_req) req_cnt++;
      @(negedge clk);
    end
    check(hi_cnt == 0, "R8 gate low after short", hi_cnt, 0);
    check(req_cnt == 1, "R7 single request before halt", req_cnt, 1);
    check(halted == 1'b1, "R8 halted after short", halted, 1);

    enable = 0;
    repeat (2) @(negedge clk);
    check(!halted && !gate, "R11 fault clears halt", {halted, gate}, 0);
    gnd_short = 0;
    @(negedge clk);
    enable = 1;
    run(10, 0, 5, -1, -1, 9, 0, "R11 restart after halt");

    ton_cyc = TW'(40);
    tdead_cyc = '0;
    i = 0;
    while (gate == 1'b0 && i < 2000) begin
      zcd = (i == 5);
      @(negedge clk);
      i++;
    end
    zcd = 0;
    repeat (10) @(negedge clk);
    check(gate == 1'b1, "R10 pulse still high", gate, 1);
    enable = 0;
    #1;
    check(gate == 1'b0, "R11 gate cut at once", gate, 0);
    @(negedge clk);
    check(gate == 1'b0, "R11 gate held low", gate, 0);
    enable = 1;
    run(10, 0, 6, -1, -1, 10, 0, "R11 restart after fault");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule